// File: doc/BRIEF.md
# Gigabit PCS Transmit Code-Group Framer

This block sits between a byte-wide gigabit MAC transmit interface and an 8B10B encoder. Each clock it takes one byte with its enable and error flags, and it emits one code group: an 8-bit value, a flag that marks it as a control (K) group, and a flag that marks the slot as even or odd. The encoder downstream turns each code group into a 10-bit symbol and reports its running disparity back to this block.

Between packets the block sends two-group idle sets, and every set starts in an even slot. When a packet starts, a start delimiter takes the place of the first preamble byte. The block sends each later byte as a data group, or as an error-propagation group when the error flag is set. After the enable falls it sends an end delimiter. It then sends one or two carrier-extend groups, so that the next idle set starts in an even slot. A packet whose enable rises in the wrong slot is pushed back one slot, and one more preamble byte is lost.

Top module: `gpcs_tx_framer`

## Requirements
- R1: While `rst_n` is low the output is K28.5 (`cg_data`=0xBC, `cg_k`=1) with `cg_even`=1.
- R2: With no packet in progress the output alternates K28.5 (0xBC, `cg_k`=1) in even slots with a data group (`cg_k`=0) in odd slots. That data group is D16.2 (0x50) if `rd_pos` was high at the clock edge that ends the K28.5 slot, and D5.6 (0xC5) if it was low.
- R3: When `tx_en` rises at an edge that opens an even slot, that slot carries the start delimiter (0xFB, `cg_k`=1) and the first byte is not forwarded. A packet of L bytes then yields L-1 data or error groups.
- R4: When `tx_en` rises at an edge that opens an odd slot, that slot still carries the idle data group and the byte is discarded. The start delimiter follows in the next (even) slot in place of the second byte, so a packet of L bytes yields L-2 data or error groups.
- R5: Each later byte sampled with `tx_en`=1 and `tx_er`=0 appears unchanged on `cg_data` with `cg_k`=0 in the slot opened by the edge that samples it, with bytes kept in order.
- R6: A packet byte sampled with `tx_er`=1 is replaced by the error-propagation group 0xFE with `cg_k`=1.
- R7: The slot opened by the first edge with `tx_en`=0 after a packet carries the end delimiter 0xFD with `cg_k`=1.
- R8: The end delimiter is followed by carrier-extend groups (0xF7, `cg_k`=1): one when the end delimiter is in an even slot, two when it is in an odd slot. The next group is K28.5 in an even slot.
- R9: `cg_even` toggles on every clock edge after reset, and K28.5 and the start delimiter only ever appear in even slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Code-group clock, one group per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| txd | input | 8 | Transmit byte from the MAC |
| tx_en | input | 1 | Byte valid, high for the whole packet |
| tx_er | input | 1 | Marks the current byte as errored |
| rd_pos | input | 1 | Running disparity from the encoder, 1 = positive |
| cg_data | output | 8 | Code-group value |
| cg_k | output | 1 | 1 = control group, 0 = data group |
| cg_even | output | 1 | 1 = current slot is even |

## Verification
Packets of even and odd length are launched with the enable rising in an even slot and in an odd slot. The count of forwarded groups and the identity of the first forwarded byte separate the plain start from the delayed start. The length parity together with the start parity places the end delimiter in both slot kinds, which tells the single carrier extension apart from the double one. An errored byte in mid-packet shows that only that one slot is replaced. A pseudo-random disparity pattern during idle tells the two second idle groups apart.

// File: rtl/gpcs_tx_pkg.sv
// Shared constants and types for the gigabit PCS transmit framer.
// Assumes 8-bit code-group values with a separate control flag.
package gpcs_tx_pkg;

    localparam int CG_W = 8;

    // Which kind of code group occupies a slot.
    typedef enum logic [2:0] {
        SEL_IDLE_K = 3'd0,
        SEL_IDLE_D = 3'd1,
        SEL_SOP    = 3'd2,
        SEL_DATA   = 3'd3,
        SEL_ERR    = 3'd4,
        SEL_EOP    = 3'd5,
        SEL_EXT    = 3'd6
    } cg_sel_e;

    localparam logic [CG_W-1:0] CG_K28_5 = 8'hBC;
    localparam logic [CG_W-1:0] CG_D16_2 = 8'h50;
    localparam logic [CG_W-1:0] CG_D5_6  = 8'hC5;
    localparam logic [CG_W-1:0] CG_SOP   = 8'hFB;
    localparam logic [CG_W-1:0] CG_EOP   = 8'hFD;
    localparam logic [CG_W-1:0] CG_EXT   = 8'hF7;
    localparam logic [CG_W-1:0] CG_ERR   = 8'hFE;

endpackage

// File: rtl/gpcs_tx_slot_parity.sv
// Even/odd slot tracker.
// Holds the parity of the slot on the outputs now and gives the parity of the
// slot that the next clock edge opens. Reset places the output on an even slot.
module gpcs_tx_slot_parity (
    input  logic clk,
    input  logic rst_n,
    output logic slot_even,
    output logic next_even
);

    // Toggle the parity on every edge; reset gives even.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_even <= 1'b1;
        else        slot_even <= ~slot_even;
    end

    // Parity of the slot the coming edge opens.
    always_comb next_even = ~slot_even;

endmodule

// File: rtl/gpcs_tx_seq.sv
// Framing sequencer.
// Picks the kind of code group for the next slot from the current kind, the
// MAC flags and the next slot parity. A start is allowed only into an even
// slot, and only once per tx_en assertion. Assumes the MAC holds tx_en high
// for the whole packet.
module gpcs_tx_seq
    import gpcs_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tx_en,
    input  logic    tx_er,
    input  logic    next_even,
    output cg_sel_e sel_q,
    output cg_sel_e sel_nxt
);

    logic consumed_q;
    logic consumed_d;
    logic start_ok;

    // A fresh assertion of tx_en may open a packet in an even slot.
    always_comb start_ok = tx_en & ~consumed_q & next_even;

    // Next-slot selection.
    always_comb begin
        sel_nxt = SEL_IDLE_K;
        unique case (sel_q)
            SEL_IDLE_K, SEL_IDLE_D: begin
                if (start_ok)       sel_nxt = SEL_SOP;
                else if (next_even) sel_nxt = SEL_IDLE_K;
                else                sel_nxt = SEL_IDLE_D;
            end
            SEL_SOP, SEL_DATA, SEL_ERR: begin
                if (!tx_en)     sel_nxt = SEL_EOP;
                else if (tx_er) sel_nxt = SEL_ERR;
                else            sel_nxt = SEL_DATA;
            end
            SEL_EOP: sel_nxt = SEL_EXT;
            SEL_EXT: sel_nxt = next_even ? SEL_IDLE_K : SEL_EXT;
            default: sel_nxt = SEL_IDLE_K;
        endcase
    end

    // The current assertion of tx_en stays consumed until tx_en drops.
    always_comb consumed_d = (sel_nxt == SEL_SOP) | (consumed_q & tx_en);

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= SEL_IDLE_K;
            consumed_q <= 1'b0;
        end else begin
            sel_q      <= sel_nxt;
            consumed_q <= consumed_d;
        end
    end

endmodule

// File: rtl/gpcs_tx_cg_map.sv
// Code-group mapper.
// Registers the payload byte for the next slot (the MAC byte, or the second
// idle group chosen by the disparity sampled as the K28.5 slot ends). It then
// maps the slot kind to the value and control flag.
module gpcs_tx_cg_map
    import gpcs_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  cg_sel_e         sel_q,
    input  cg_sel_e         sel_nxt,
    input  logic [CG_W-1:0] txd,
    input  logic            rd_pos,
    output logic [CG_W-1:0] cg_data,
    output logic            cg_k
);

    logic [CG_W-1:0] byte_q;

    // Capture the payload for the slot being opened.
    always_ff @(posedge clk) begin
        if (!rst_n)                     byte_q <= '0;
        else if (sel_nxt == SEL_IDLE_D) byte_q <= rd_pos ? CG_D16_2 : CG_D5_6;
        else                            byte_q <= txd;
    end

    // Map the slot kind to the code group on the outputs.
    always_comb begin
        cg_data = CG_K28_5;
        cg_k    = 1'b1;
        unique case (sel_q)
            SEL_IDLE_K: begin cg_data = CG_K28_5; cg_k = 1'b1; end
            SEL_IDLE_D: begin cg_data = byte_q;   cg_k = 1'b0; end
            SEL_SOP:    begin cg_data = CG_SOP;   cg_k = 1'b1; end
            SEL_DATA:   begin cg_data = byte_q;   cg_k = 1'b0; end
            SEL_ERR:    begin cg_data = CG_ERR;   cg_k = 1'b1; end
            SEL_EOP:    begin cg_data = CG_EOP;   cg_k = 1'b1; end
            SEL_EXT:    begin cg_data = CG_EXT;   cg_k = 1'b1; end
            default:    begin cg_data = CG_K28_5; cg_k = 1'b1; end
        endcase
    end

endmodule

// File: rtl/gpcs_tx_framer.sv
// Gigabit PCS transmit framer top.
// Turns a byte stream with enable/error flags into one code group per clock.
// It frames packets with delimiters and carrier extension, and fills the gaps
// with even-aligned idle sets. Assumes rd_pos is valid at every edge.
module gpcs_tx_framer
    import gpcs_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CG_W-1:0] txd,
    input  logic            tx_en,
    input  logic            tx_er,
    input  logic            rd_pos,
    output logic [CG_W-1:0] cg_data,
    output logic            cg_k,
    output logic            cg_even
);

    logic    next_even;
    cg_sel_e sel_q;
    cg_sel_e sel_nxt;

    // Slot parity.
    gpcs_tx_slot_parity u_parity (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_even (cg_even),
        .next_even (next_even)
    );

    // Framing decisions.
    gpcs_tx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .tx_er     (tx_er),
        .next_even (next_even),
        .sel_q     (sel_q),
        .sel_nxt   (sel_nxt)
    );

    // Code-group values.
    gpcs_tx_cg_map u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_q   (sel_q),
        .sel_nxt (sel_nxt),
        .txd     (txd),
        .rd_pos  (rd_pos),
        .cg_data (cg_data),
        .cg_k    (cg_k)
    );

endmodule

// File: rtl/gpcs_tx_framer_chk.sv
// Port-level checker for the framer, bound to every instance of it.
module gpcs_tx_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_er,
    input logic       rd_pos,
    input logic [7:0] cg_data,
    input logic       cg_k,
    input logic       cg_even
);

    logic is_k285, is_sop, is_eop, is_ext, is_err;

    // Decode the code groups on the outputs.
    always_comb begin
        is_k285 = cg_k && (cg_data == 8'hBC);
        is_sop  = cg_k && (cg_data == 8'hFB);
        is_eop  = cg_k && (cg_data == 8'hFD);
        is_ext  = cg_k && (cg_data == 8'hF7);
        is_err  = cg_k && (cg_data == 8'hFE);
    end

    p_parity_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cg_even != $past(cg_even)));

    p_k285_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_k285 |-> cg_even);

    p_sop_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_sop |-> cg_even);

    p_idle_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_k285 |=> (!cg_k && (cg_data == ($past(rd_pos) ? 8'h50 : 8'hC5))));

    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_err |-> $past(tx_er));

    p_eop_then_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_eop |=> is_ext);

    p_ext_even_more_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ext && cg_even) |=> is_ext);

    p_ext_odd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ext && !cg_even) |=> is_k285);

endmodule

bind gpcs_tx_framer gpcs_tx_framer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_er   (tx_er),
    .rd_pos  (rd_pos),
    .cg_data (cg_data),
    .cg_k    (cg_k),
    .cg_even (cg_even)
);

// File: tb/test_gpcs_tx_framer.sv
// Directed bench: a per-slot reference model built from the requirements, plus
// per-scenario checks of packet shape.
module test_gpcs_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] txd = 8'h00;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic       rd_pos = 1'b0;
    logic [7:0] cg_data;
    logic       cg_k;
    logic       cg_even;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    logic [7:0] lfsr = 8'h5A;

    // reference model state
    int  m_mode = 0;      // 0 idle, 2 packet, 3 extension
    bit  m_even = 1;
    bit  m_seen = 0;
    int  m_left = 0;
    logic [7:0] m_data;
    bit  m_k;

    // observed packet shape
    bit  in_pkt = 0;
    int  data_cnt = 0;
    int  ext_cnt = 0;
    bit  got_first = 0;
    logic [7:0] first_data = 8'h00;

    always #4 clk = ~clk;

    gpcs_tx_framer i_gpcs_tx_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .txd     (txd),
        .tx_en   (tx_en),
        .tx_er   (tx_er),
        .rd_pos  (rd_pos),
        .cg_data (cg_data),
        .cg_k    (cg_k),
        .cg_even (cg_even)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One slot: drive inputs, clock, advance the model, compare.
    task automatic step(input logic en, input logic er, input logic [7:0] d);
        bit    nev;
        string tag;
        lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_en  = en;
        tx_er  = er;
        txd    = d;
        rd_pos = lfsr[0];
        @(posedge clk);
        #1;
        nev = !m_even;
        tag = "R2";
        case (m_mode)
            0: begin
                if (nev && en && !m_seen) begin
                    m_data = 8'hFB; m_k = 1; m_mode = 2; m_seen = 1; tag = "R3";
                end else if (nev) begin
                    m_data = 8'hBC; m_k = 1;
                end else begin
                    m_data = rd_pos ? 8'h50 : 8'hC5; m_k = 0;
                end
            end
            2: begin
                if (en && er) begin
                    m_data = 8'hFE; m_k = 1; tag = "R6";
                end else if (en) begin
                    m_data = d; m_k = 0; tag = "R5";
                end else begin
                    m_data = 8'hFD; m_k = 1; m_mode = 3; tag = "R7";
                    m_left = nev ? 1 : 2;
                end
            end
            default: begin
                m_data = 8'hF7; m_k = 1; tag = "R8";
                m_left--;
                if (m_left == 0) m_mode = 0;
            end
        endcase
        if (!en) m_seen = 0;
        m_even = nev;
        chk({tag, " data"}, cg_data, m_data);
        chk({tag, " k"}, cg_k, m_k);
        chk("R9 parity", cg_even, m_even);
        // observed shape
        if (cg_k && cg_data == 8'hFB) begin
            in_pkt = 1; data_cnt = 0; ext_cnt = 0; got_first = 0;
        end else if (cg_k && cg_data == 8'hFD) begin
            in_pkt = 0;
        end else if (cg_k && cg_data == 8'hF7) begin
            ext_cnt++;
        end else if (in_pkt) begin
            data_cnt++;
            if (!got_first) begin first_data = cg_data; got_first = 1; end
        end
    endtask

    task automatic t_reset();
        repeat (2) begin
            @(posedge clk);
            #1;
            chk("R1 data", cg_data, 8'hBC);
            chk("R1 k", cg_k, 1);
            chk("R1 even", cg_even, 1);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        repeat (24) step(0, 0, 8'h00);  // R2 R9 via the model
    endtask

    // Packet of len bytes, bytes 8'h10+i, one errored byte at err_idx (-1 none).
    task automatic t_packet(input int len, input bit odd_start, input int err_idx);
        int exp_cnt;
        int exp_ext;
        bit t_even;
        step(0, 0, 8'h00);
        step(0, 0, 8'h00);
        while (cg_even !== odd_start) step(0, 0, 8'h00);
        for (int i = 0; i < len; i++) step(1, (i == err_idx), 8'h10 + 8'(i));
        repeat (5) step(0, 0, 8'h00);
        exp_cnt = odd_start ? len - 2 : len - 1;
        chk(odd_start ? "R4 group count" : "R3 group count", data_cnt, exp_cnt);
        chk(odd_start ? "R4 first byte" : "R3 first byte", first_data,
            8'h10 + (odd_start ? 8'd2 : 8'd1));
        t_even = odd_start ? (len % 2 == 1) : (len % 2 == 0);
        exp_ext = t_even ? 1 : 2;
        chk("R8 extend count", ext_cnt, exp_ext);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_packet(8, 0, -1);   // R3, even length, T even
        t_packet(9, 0, -1);   // R3, odd length, T odd
        t_packet(8, 1, -1);   // R4, T odd
        t_packet(9, 1, -1);   // R4, T even
        t_packet(12, 0, 6);   // R6 mid-packet error
        t_packet(11, 1, 4);   // R6 with odd start
        t_idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule